// File: doc/BRIEF.md
# Prefetch Stream Stop Queue

This block takes stop requests for a set of background prefetch streams and turns them into per-stream valid-clear pulses for the stream table. Each of the four streams has a 2-bit tag, and each tag owns one fixed slot in the queue. Requests arrive already decoded and non-speculative. A request either names one tag, or carries an all-streams flag that stops every stream. The stream engine is offered one pending slot at a time through a valid/acknowledge handshake. In the cycle the acknowledge is taken, the block clears that stream's valid bit in the table.

A second stop for a tag whose slot is still pending waits in a one-deep hold stage. While the hold stage is full, the upstream ready signal is dropped. A new stream start for a tag cancels that tag's pending stop, so the stream is never cleared. A stop-all does not act when it is accepted. It waits until the pipeline reports it as the oldest operation, and only then fills every slot. Completing a stop only keeps the stream from issuing further line fetches. Fetches already in flight are left alone.

Top module: `streamStopQueue`

## Requirements
- R1: After a synchronous reset: `stopReady` is 1, `doneValid` is 0, and `vtClear` is all zeros.
- R2: A single-tag stop (`stopAll`=0) accepted while its tag's slot is empty makes that slot pending from the next cycle, so that `doneValid` is 1.
- R3: When `doneValid` and `doneAck` are both 1 and there is no start for the same tag, `vtClear` carries exactly bit `doneTag`, in that same cycle. The slot is then removed, and its tag is never offered again unless a new stop is queued.
- R4: When several slots are pending, `doneTag` names the lowest pending tag. Each acknowledge retires exactly one slot.
- R5: A single-tag stop accepted while its tag's slot is pending goes into the hold stage. `stopReady` is 0 while the hold stage is occupied. The cycle after the earlier slot retires, the held stop fills the slot, and it is offered again one cycle later.
- R6: A start (`startValid`=1, `startTag`=t) removes a pending stop for tag t with no pulse on `vtClear`. Slots for other tags are not touched.
- R7: If a start and an acknowledged completion name the same tag in the same cycle, the start wins. `vtClear` stays 0 and the slot is removed.
- R8: A stop with `stopAll`=1 ignores `stopTag`. From its acceptance until it fills the slots, `stopReady` is 0. It fills all four slots in the cycle `isOldest` is 1. The slots are then offered in the order 0, 1, 2, 3.
- R9: While an accepted stop-all waits with `isOldest`=0, no slot is filled by it.
- R10: A request presented while `stopReady` is 0 is ignored and leaves no slot pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stopValid | input | 1 | A non-speculative stop request is presented |
| stopAll | input | 1 | Request targets all streams; `stopTag` ignored |
| stopTag | input | 2 | Stream tag for a single-stream stop |
| stopReady | output | 1 | The block can take a request this cycle |
| isOldest | input | 1 | The waiting stop-all is the oldest operation |
| startValid | input | 1 | A stream start is being queued in the stream table |
| startTag | input | 2 | Tag of the starting stream |
| doneValid | output | 1 | A stop slot is offered to the stream engine |
| doneTag | output | 2 | Tag of the offered slot |
| doneAck | input | 1 | The stream engine takes the offered slot |
| vtClear | output | 4 | One-hot pulse that clears a stream-table valid bit |

## Verification
The hardest condition to reach is the hold stage draining. It needs a pending slot, a colliding stop behind it, and then an acknowledge. After that the held request must reappear exactly one idle cycle later. The stimulus issues two stops to tag 0 back to back. While ready is low, it also tries a stop to tag 3, which must be ignored. It then acknowledges and counts cycles until tag 0 is offered again. The start-versus-completion race is forced by raising `startValid` and `doneAck` for the same tag in the same cycle. The scoreboard expects no clear pulse for that race.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  parameter int NUM_STREAMS = 4;
  localparam int TAG_W = $clog2(NUM_STREAMS);

  typedef logic [NUM_STREAMS-1:0] mask_t;
  typedef logic [TAG_W-1:0]       tag_t;

  // strobes from control to datapath
  typedef struct packed {
    mask_t setMask;
    mask_t clrMask;
    logic  holdLoad;
    logic  holdClear;
    tag_t  holdTagIn;
    logic  allSet;
    logic  allClear;
  } strobe_t;

  function automatic mask_t tagMask(input tag_t t);
    mask_t m;
    m = '0;
    m[t] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ssqDatapath.sv
module ssqDatapath
  import ssq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  strobe_t strobe,
  output mask_t   pend,
  output logic    holdValid,
  output tag_t    holdTag,
  output logic    allPend,
  output logic    doneValid,
  output tag_t    doneTag
);
  mask_t pendQ;
  logic  holdValidQ;
  tag_t  holdTagQ;
  logic  allPendQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ      <= '0;
      holdValidQ <= 1'b0;
      holdTagQ   <= '0;
      allPendQ   <= 1'b0;
    end else begin
      // clears first, new loads take precedence
      pendQ <= (pendQ & ~strobe.clrMask) | strobe.setMask;
      if (strobe.holdLoad) begin
        holdValidQ <= 1'b1;
        holdTagQ   <= strobe.holdTagIn;
      end else if (strobe.holdClear) begin
        holdValidQ <= 1'b0;
      end
      if (strobe.allSet)        allPendQ <= 1'b1;
      else if (strobe.allClear) allPendQ <= 1'b0;
    end
  end

  // lowest pending tag wins
  always_comb begin
    doneTag = '0;
    for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
      if (pendQ[i]) doneTag = tag_t'(i);
    end
  end

  assign doneValid = |pendQ;
  assign pend      = pendQ;
  assign holdValid = holdValidQ;
  assign holdTag   = holdTagQ;
  assign allPend   = allPendQ;
endmodule

// File: rtl/ssqCtrl.sv
module ssqCtrl
  import ssq_pkg::*;
(
  input  logic    stopValid,
  input  logic    stopAll,
  input  tag_t    stopTag,
  input  logic    isOldest,
  input  logic    startValid,
  input  tag_t    startTag,
  input  logic    doneAck,
  input  mask_t   pend,
  input  logic    holdValid,
  input  tag_t    holdTag,
  input  logic    allPend,
  input  logic    doneValid,
  input  tag_t    doneTag,
  output logic    stopReady,
  output mask_t   vtClear,
  output strobe_t strobe
);
  logic  acceptOne;
  logic  acceptAll;
  logic  collide;
  logic  drain;
  logic  fanOut;
  mask_t doneMask;
  mask_t cancelMask;
  mask_t acceptMask;
  mask_t drainMask;

  assign stopReady  = !holdValid && !allPend;
  assign acceptOne  = stopValid && stopReady && !stopAll;
  assign acceptAll  = stopValid && stopReady && stopAll;
  assign collide    = acceptOne && pend[stopTag];
  assign drain      = holdValid && !pend[holdTag];
  assign fanOut     = allPend && isOldest;

  assign doneMask   = (doneValid && doneAck) ? tagMask(doneTag) : '0;
  assign cancelMask = startValid ? tagMask(startTag) : '0;
  assign acceptMask = (acceptOne && !collide) ? tagMask(stopTag) : '0;
  assign drainMask  = drain ? tagMask(holdTag) : '0;

  // a start on the same tag overrides the completion
  assign vtClear = doneMask & ~cancelMask;

  always_comb begin
    strobe           = '0;
    strobe.clrMask   = doneMask | cancelMask;
    strobe.setMask   = acceptMask | drainMask | (fanOut ? '1 : '0);
    strobe.holdLoad  = collide;
    strobe.holdClear = drain;
    strobe.holdTagIn = stopTag;
    strobe.allSet    = acceptAll;
    strobe.allClear  = fanOut;
  end
endmodule

// File: rtl/streamStopQueue.sv
module streamStopQueue
  import ssq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   stopValid,
  input  logic                   stopAll,
  input  logic [TAG_W-1:0]       stopTag,
  output logic                   stopReady,
  input  logic                   isOldest,
  input  logic                   startValid,
  input  logic [TAG_W-1:0]       startTag,
  output logic                   doneValid,
  output logic [TAG_W-1:0]       doneTag,
  input  logic                   doneAck,
  output logic [NUM_STREAMS-1:0] vtClear
);
  strobe_t strobe;
  mask_t   pend;
  logic    holdValid;
  tag_t    holdTag;
  logic    allPend;

  ssqCtrl u_ctrl (
    .stopValid (stopValid),
    .stopAll   (stopAll),
    .stopTag   (stopTag),
    .isOldest  (isOldest),
    .startValid(startValid),
    .startTag  (startTag),
    .doneAck   (doneAck),
    .pend      (pend),
    .holdValid (holdValid),
    .holdTag   (holdTag),
    .allPend   (allPend),
    .doneValid (doneValid),
    .doneTag   (doneTag),
    .stopReady (stopReady),
    .vtClear   (vtClear),
    .strobe    (strobe)
  );

  ssqDatapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .pend     (pend),
    .holdValid(holdValid),
    .holdTag  (holdTag),
    .allPend  (allPend),
    .doneValid(doneValid),
    .doneTag  (doneTag)
  );
endmodule

// File: rtl/streamStopQueueChk.sv
module streamStopQueueChk
  import ssq_pkg::*;
(
  input logic                   clk,
  input logic                   rst,
  input logic                   stopValid,
  input logic                   stopAll,
  input logic [TAG_W-1:0]       stopTag,
  input logic                   stopReady,
  input logic                   isOldest,
  input logic                   startValid,
  input logic [TAG_W-1:0]       startTag,
  input logic                   doneValid,
  input logic [TAG_W-1:0]       doneTag,
  input logic                   doneAck,
  input logic [NUM_STREAMS-1:0] vtClear
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!doneValid && vtClear == '0 && stopReady));

  // R2
  stop_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (stopValid && stopReady && !stopAll && !doneValid) |=> doneValid);

  // R3
  clear_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vtClear));

  // R3
  clear_matches_offer_chk: assert property (@(posedge clk) disable iff (rst)
    (vtClear != '0) |-> (doneValid && doneAck && vtClear == tagMask(doneTag)));

  // R7
  start_blocks_clear_chk: assert property (@(posedge clk) disable iff (rst)
    startValid |-> (vtClear[startTag] == 1'b0));

  // R8
  all_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (stopValid && stopReady && stopAll) |=> !stopReady);

  // R4
  offer_held_chk: assert property (@(posedge clk) disable iff (rst)
    (doneValid && !doneAck && !startValid) |=> doneValid);
endmodule

bind streamStopQueue streamStopQueueChk u_chk (
  .clk       (clk),
  .rst       (rst),
  .stopValid (stopValid),
  .stopAll   (stopAll),
  .stopTag   (stopTag),
  .stopReady (stopReady),
  .isOldest  (isOldest),
  .startValid(startValid),
  .startTag  (startTag),
  .doneValid (doneValid),
  .doneTag   (doneTag),
  .doneAck   (doneAck),
  .vtClear   (vtClear)
);

// File: tb/streamStopQueue_bench.sv
module streamStopQueue_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stopValid = 1'b0;
  logic       stopAll = 1'b0;
  logic [1:0] stopTag = '0;
  logic       stopReady;
  logic       isOldest = 1'b0;
  logic       startValid = 1'b0;
  logic [1:0] startTag = '0;
  logic       doneValid;
  logic [1:0] doneTag;
  logic       doneAck = 1'b0;
  logic [3:0] vtClear;

  int tests = 0;
  int fails = 0;
  int expQ[$];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  streamStopQueue u_streamStopQueue (
    .clk(clk), .rst(rst),
    .stopValid(stopValid), .stopAll(stopAll), .stopTag(stopTag),
    .stopReady(stopReady), .isOldest(isOldest),
    .startValid(startValid), .startTag(startTag),
    .doneValid(doneValid), .doneTag(doneTag), .doneAck(doneAck),
    .vtClear(vtClear)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic issueStop(input logic [1:0] tag, input logic all);
    stopValid = 1'b1; stopTag = tag; stopAll = all;
    tick();
    stopValid = 1'b0; stopAll = 1'b0;
  endtask

  task automatic expectOffer(input int tag, input string req);
    @(negedge clk);
    chk(doneValid == 1'b1, req, int'(doneValid), 1);
    chk(int'(doneTag) == tag, req, int'(doneTag), tag);
  endtask

  task automatic expectIdle(input string req);
    @(negedge clk);
    chk(doneValid == 1'b0, req, int'(doneValid), 0);
  endtask

  // driver: push expected clear, then acknowledge
  task automatic ackOne(input int tag, input string req);
    expectOffer(tag, req);
    expQ.push_back(tag);
    doneAck = 1'b1;
    tick();
    doneAck = 1'b0;
  endtask

  // monitor: compare every clear pulse against the scoreboard
  always @(negedge clk) begin
    if (!rst && vtClear != '0) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R3/R6 unexpected clear", int'(vtClear), 0);
      end else begin
        automatic int e = expQ.pop_front();
        chk(vtClear == (4'b1 << e), "R3 clear pulse", int'(vtClear), 1 << e);
      end
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(stopReady == 1'b1, "R1 ready", int'(stopReady), 1);
    chk(doneValid == 1'b0, "R1 doneValid", int'(doneValid), 0);
    chk(vtClear == '0, "R1 vtClear", int'(vtClear), 0);

    // R2 / R3: single stop then completion
    tick();
    issueStop(2'd2, 1'b0);
    ackOne(2, "R2 offer tag2");
    expectIdle("R3 slot removed");

    // R4: lowest tag first
    tick();
    issueStop(2'd3, 1'b0);
    issueStop(2'd1, 1'b0);
    issueStop(2'd2, 1'b0);
    ackOne(1, "R4 first");
    ackOne(2, "R4 second");
    ackOne(3, "R4 third");
    expectIdle("R4 drained");

    // R5 / R10: collision into hold, ignored request while not ready
    tick();
    issueStop(2'd0, 1'b0);
    issueStop(2'd0, 1'b0);
    @(negedge clk);
    chk(stopReady == 1'b0, "R5 ready low while held", int'(stopReady), 1'b0);
    tick();
    issueStop(2'd3, 1'b0);             // ignored: R10
    ackOne(0, "R5 first tag0");
    @(negedge clk);
    chk(doneValid == 1'b0, "R5 gap cycle", int'(doneValid), 0);
    chk(stopReady == 1'b0, "R5 hold still full", int'(stopReady), 0);
    tick();
    expectOffer(0, "R5 held stop offered");
    chk(stopReady == 1'b1, "R5 ready back", int'(stopReady), 1);
    ackOne(0, "R5 second tag0");
    expectIdle("R10 ignored stop left nothing");

    // R6: start cancels only its own tag
    tick();
    issueStop(2'd1, 1'b0);
    startValid = 1'b1; startTag = 2'd1;
    tick();
    startValid = 1'b0;
    expectIdle("R6 cancelled");
    tick();
    issueStop(2'd2, 1'b0);
    startValid = 1'b1; startTag = 2'd0;
    tick();
    startValid = 1'b0;
    ackOne(2, "R6 other tag kept");

    // R7: start and completion race on the same tag
    tick();
    issueStop(2'd3, 1'b0);
    startValid = 1'b1; startTag = 2'd3; doneAck = 1'b1;
    @(negedge clk);
    chk(vtClear == '0, "R7 no clear", int'(vtClear), 0);
    tick();
    startValid = 1'b0; doneAck = 1'b0;
    expectIdle("R7 slot removed");

    // R8 / R9: stop-all waits for oldest, tag bits ignored
    tick();
    issueStop(2'd2, 1'b1);
    @(negedge clk);
    chk(stopReady == 1'b0, "R8 ready low", int'(stopReady), 0);
    chk(doneValid == 1'b0, "R9 waiting", int'(doneValid), 0);
    repeat (3) tick();
    expectIdle("R9 still waiting");
    isOldest = 1'b1;
    tick();
    isOldest = 1'b0;
    @(negedge clk);
    chk(stopReady == 1'b1, "R8 ready after fan-out", int'(stopReady), 1);
    ackOne(0, "R8 slot0");
    ackOne(1, "R8 slot1");
    ackOne(2, "R8 slot2");
    ackOne(3, "R8 slot3");
    expectIdle("R8 all drained");

    tick();
    chk(expQ.size() == 0, "R3 scoreboard empty", expQ.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule